// File: doc/BRIEF.md
# Staged Clock-Configuration Commit Bank

This block holds a bank of clock-configuration words. Each word has two copies. Software writes the staging copy over a word-addressed memory-mapped bus. The active copy drives the clock dividers and gates downstream. Software can fill in any number of staging words and then issue one load command through the control word. That command moves every staging word into its active copy at the same clock edge, so the downstream clock tree never sees a mix of old and new settings.

The control word lives at address 0 and the configuration slots start at address 1. The control word carries two bits:
- **Load command.** A write-only trigger that hardware clears by itself.
- **Commit status flag.** It drops on every write to a staging word and comes back when a commit lands.

The bus request side is valid/ready. `req_ready` is held high, so the block never applies back-pressure and every request with `req_valid` high is taken at that clock edge. The read response has no ready. It comes back on `rsp_valid`/`rsp_rdata` exactly one cycle after the read is taken, and the master must take it in that cycle.

Top module: `cfg_commit_bank`

## Requirements
- R1: After reset, every staging and active word is zero, `load_done` is 1, and a read of the control word (address 0) returns 0x00000002.
- R2: A write to address k+1 (k below NUM_SLOTS) stores the full data word in staging slot k. A later read of that address returns the staged value.
- R3: Active words on `cfg_active` change only on a commit. Slot k drives bits [k*DATA_W +: DATA_W]. Staging writes alone never change them.
- R4: Writing the control word with bit 0 set starts a commit. At the clock edge one cycle after the write is accepted, every active word takes its staging value together.
- R5: Bit 0 of the control word always reads as 0. The load command clears itself and software never clears it.
- R6: Any accepted write to a staging slot drives `load_done` (control bit 1) to 0 at that edge, even when the written value equals the stored one. The only exception is a write that lands on a commit edge.
- R7: A commit sets `load_done` to 1 at the commit edge.
- R8: A staging write accepted on the commit edge, one cycle after the load write, is stored first and is included in that commit. `load_done` ends that edge at 1.
- R9: The following writes leave `load_done`, the staging words and the active words unchanged:
  - a control write with bit 0 clear;
  - writes to control bits DATA_W-1..1;
  - writes to unmapped addresses (above NUM_SLOTS).

  Control bits DATA_W-1..2 always read 0.
- R10: `req_ready` is always 1. A read accepted at an edge yields `rsp_valid`=1 for exactly the next cycle. The data in that response is the state before that edge, and an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address: 0 = control, 1..NUM_SLOTS = slots |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | DATA_W | Read data |
| cfg_active | output | NUM_SLOTS*DATA_W | Active configuration words, slot k at [k*DATA_W +: DATA_W] |
| load_done | output | 1 | Commit status, mirrors control bit 1 |

## Verification
Results fall due at these times, counted from the edge that accepts a request:
- A staging write shows on a read and on `load_done` right after that edge.
- A read response shows in the cycle after that edge.
- A load write moves `cfg_active` and sets `load_done` only after the following edge.

The bench drives every input just after the falling edge. A behavioural model in the bench updates on the same rising edge as the block. Every output is compared with the model at the next falling edge, and each directed check waits the matching number of cycles. The case where a staging write lands on the commit edge is driven back to back with the load write, so the model's ordering decides the expected value.

// File: rtl/cfg_commit_pkg.sv
package cfg_commit_pkg;
  // control word layout: these positions are decoded by software
  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned LOAD_BIT  = 0;
  localparam int unsigned DONE_BIT  = 1;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CTRL = 2'd1,
    TGT_SLOT = 2'd2
  } target_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_commit_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 6,
  parameter int unsigned ADDR_W    = 4,
  localparam int unsigned IDX_W    = idx_width(NUM_SLOTS)
) (
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 load_bit,
  output target_e              tgt,
  output logic [IDX_W-1:0]     slot_idx,
  output logic [NUM_SLOTS-1:0] slot_we,
  output logic                 load_req
);
  logic wr_acc;

  assign wr_acc = req_valid && req_write;

  always_comb begin
    if (req_addr == ADDR_W'(CTRL_ADDR))
      tgt = TGT_CTRL;
    else if (int'(req_addr) <= int'(NUM_SLOTS))
      tgt = TGT_SLOT;
    else
      tgt = TGT_NONE;
  end

  assign slot_idx = IDX_W'(req_addr - ADDR_W'(1));
  assign load_req = wr_acc && (tgt == TGT_CTRL) && load_bit;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_we
    assign slot_we[i] = wr_acc && (tgt == TGT_SLOT) &&
                        (req_addr == ADDR_W'(i + 1));
  end
endmodule

// File: rtl/cfg_stage_slot.sv
module cfg_stage_slot #(
  parameter int unsigned     DATA_W    = 32,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              commit,
  output logic [DATA_W-1:0] stage_q,
  output logic [DATA_W-1:0] active_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q  <= RESET_VAL;
      active_q <= RESET_VAL;
    end else begin
      if (we)
        stage_q <= wdata;
      if (commit)
        active_q <= we ? wdata : stage_q;
    end
  end

  // R3
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active_q));

  // R4
  active_matches_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (active_q == stage_q));
endmodule

// File: rtl/cfg_commit_seq.sv
module cfg_commit_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic load_req,
  input  logic stage_wr,
  output logic commit,
  output logic load_done
);
  logic load_pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      load_pend_q <= 1'b0;
    else
      load_pend_q <= load_req;
  end

  assign commit = load_pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      load_done <= 1'b1;
    else if (commit)
      load_done <= 1'b1;
    else if (stage_wr)
      load_done <= 1'b0;
  end

  // R4
  load_to_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> commit);

  // R7
  commit_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> load_done);

  // R6
  stage_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_wr && !commit) |=> !load_done);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stage_wr && !commit) |=> $stable(load_done));
endmodule

// File: rtl/cfg_commit_bank.sv
module cfg_commit_bank
  import cfg_commit_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 6,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  localparam int unsigned IDX_W    = idx_width(NUM_SLOTS),
  localparam int unsigned ACT_W    = NUM_SLOTS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ACT_W-1:0]  cfg_active,
  output logic              load_done
);
  target_e              tgt;
  logic [IDX_W-1:0]     slot_idx;
  logic [NUM_SLOTS-1:0] slot_we;
  logic                 load_req;
  logic                 commit;
  logic [DATA_W-1:0]    stage_arr [NUM_SLOTS];
  logic [DATA_W-1:0]    rd_data;
  logic                 rd_acc;

  assign req_ready = 1'b1;
  assign rd_acc    = req_valid && !req_write;

  cfg_addr_decode #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W)
  ) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .load_bit  (req_wdata[LOAD_BIT]),
    .tgt       (tgt),
    .slot_idx  (slot_idx),
    .slot_we   (slot_we),
    .load_req  (load_req)
  );

  cfg_commit_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_req  (load_req),
    .stage_wr  (|slot_we),
    .commit    (commit),
    .load_done (load_done)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    cfg_stage_slot #(
      .DATA_W    (DATA_W),
      .RESET_VAL ('0)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (slot_we[i]),
      .wdata    (req_wdata),
      .commit   (commit),
      .stage_q  (stage_arr[i]),
      .active_q (cfg_active[i*DATA_W +: DATA_W])
    );
  end

  // read mux: staged values for slots, status only for control
  always_comb begin
    rd_data = '0;
    case (tgt)
      TGT_CTRL: rd_data[DONE_BIT] = load_done;
      TGT_SLOT: rd_data = stage_arr[slot_idx];
      default:  rd_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_acc;
      rsp_rdata <= rd_acc ? rd_data : '0;
    end
  end

  // R10
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);

  // R10
  rsp_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rsp_valid);

  // R5
  load_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && tgt == TGT_CTRL) |=> (rsp_rdata[LOAD_BIT] == 1'b0));

  // R8
  write_and_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (|slot_we)) |=> load_done);
endmodule

// File: tb/cfg_commit_bank_tb.sv
module cfg_commit_bank_tb;
  localparam int N  = 6;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [N*DW-1:0] cfg_active;
  logic          load_done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // behavioural reference state
  logic [DW-1:0] m_stage [N];
  logic [DW-1:0] m_active [N];
  logic          m_done;
  logic          m_pend;
  logic          m_rsp_valid;
  logic [DW-1:0] m_rsp;
  logic          m_wrote;
  logic          m_newpend;

  always #10 clk = ~clk;

  cfg_commit_bank #(.NUM_SLOTS(N), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_active(cfg_active), .load_done(load_done)
  );

  function automatic logic [DW-1:0] m_read(input int a);
    if (a == 0) return DW'(m_done) << 1;
    if (a >= 1 && a <= N) return m_stage[a-1];
    return '0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin
        m_stage[k] = '0;
        m_active[k] = '0;
      end
      m_done = 1'b1; m_pend = 1'b0; m_rsp_valid = 1'b0; m_rsp = '0;
    end else begin
      m_rsp_valid = req_valid && !req_write;
      m_rsp = m_rsp_valid ? m_read(int'(req_addr)) : '0;
      m_wrote = 1'b0;
      m_newpend = 1'b0;
      if (req_valid && req_write) begin
        if (int'(req_addr) >= 1 && int'(req_addr) <= N) begin
          m_stage[int'(req_addr)-1] = req_wdata;
          m_wrote = 1'b1;
        end else if (req_addr == 0 && req_wdata[0]) begin
          m_newpend = 1'b1;
        end
      end
      if (m_pend) begin
        for (int k = 0; k < N; k++) m_active[k] = m_stage[k];
        m_done = 1'b1;
      end else if (m_wrote) begin
        m_done = 1'b0;
      end
      m_pend = m_newpend;
    end
  end

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R10 rsp_valid vs model", DW'(rsp_valid), DW'(m_rsp_valid));
      if (m_rsp_valid) check("R10 rsp_rdata vs model", rsp_rdata, m_rsp);
      check("R6 R7 load_done vs model", DW'(load_done), DW'(m_done));
      check("R10 req_ready", DW'(req_ready), DW'(1));
      for (int k = 0; k < N; k++)
        check("R3 R4 cfg_active vs model", cfg_active[k*DW +: DW], m_active[k]);
    end
  end

  task automatic drive(input logic v, input logic w, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = AW'(a); req_wdata = d;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 0, '0);
  endtask

  task automatic read_check(input int a, input logic [DW-1:0] exp, input string tag);
    drive(1'b1, 1'b0, a, '0);
    idle();
    #1;
    check(tag, DW'(rsp_valid), DW'(1));
    check(tag, rsp_rdata, exp);
  endtask

  function automatic logic [DW-1:0] act(input int k);
    return cfg_active[k*DW +: DW];
  endfunction

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 load_done in reset", DW'(load_done), DW'(1));
    check("R1 active slot0 in reset", act(0), '0);
    rst_n = 1'b1;
    read_check(0, 32'h2, "R1 ctrl reset value");
    read_check(3, 32'h0, "R1 staging reset value");

    // R2 staged write and read back, R3 active untouched
    drive(1'b1, 1'b1, 1, 32'hA5A5_0001); idle(); #1;
    check("R6 done cleared by staging write", DW'(load_done), DW'(0));
    read_check(1, 32'hA5A5_0001, "R2 staged read back");
    check("R3 active unchanged before load", act(0), '0);
    drive(1'b1, 1'b1, 2, 32'h1234_5678);
    drive(1'b1, 1'b1, 6, 32'hFFFF_0000);
    idle(); #1;
    check("R3 slot1 active held", act(1), '0);
    check("R3 slot5 active held", act(5), '0);

    // R4 commit one cycle after load write
    drive(1'b1, 1'b1, 0, 32'h1);
    idle(); #1;
    check("R4 no commit yet", act(0), '0);
    idle(); #1;
    check("R4 slot0 committed", act(0), 32'hA5A5_0001);
    check("R4 slot1 committed", act(1), 32'h1234_5678);
    check("R4 slot5 committed", act(5), 32'hFFFF_0000);
    check("R7 done after commit", DW'(load_done), DW'(1));
    read_check(0, 32'h2, "R5 load bit reads zero");

    // R6 same-value write still clears done
    drive(1'b1, 1'b1, 1, 32'hA5A5_0001); idle(); #1;
    check("R6 same value clears done", DW'(load_done), DW'(0));

    // R8 staging write on the commit edge
    drive(1'b1, 1'b1, 0, 32'h1);
    drive(1'b1, 1'b1, 4, 32'hDEAD_BEEF);
    idle(); #1;
    check("R8 folded write committed", act(3), 32'hDEAD_BEEF);
    check("R8 done ends at 1", DW'(load_done), DW'(1));

    // R9 writes that must have no effect
    drive(1'b1, 1'b1, 0, 32'h0);
    drive(1'b1, 1'b1, 0, 32'hFFFF_FFFE);
    drive(1'b1, 1'b1, 15, 32'h5555_5555);
    idle(); #1;
    check("R9 done kept at 1", DW'(load_done), DW'(1));
    check("R9 active kept", act(3), 32'hDEAD_BEEF);
    read_check(0, 32'h2, "R9 reserved bits read zero");
    read_check(15, 32'h0, "R10 unmapped read zero");
    drive(1'b1, 1'b1, 5, 32'h0000_0042);
    drive(1'b1, 1'b1, 0, 32'hFFFF_FFFE);
    idle(); #1;
    check("R9 done kept at 0", DW'(load_done), DW'(0));
    check("R9 active slot4 untouched", act(4), '0);

    // R10 back-to-back reads
    drive(1'b1, 1'b0, 2, '0);
    drive(1'b1, 1'b0, 5, '0);
    #1;
    check("R10 first of pair", rsp_rdata, 32'h1234_5678);
    idle(); #1;
    check("R10 second of pair", rsp_rdata, 32'h0000_0042);

    // mixed traffic, compared to the model every cycle
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      drive(lf[5] | lf[6], lf[4], int'(lf[3:0]), {lf, ~lf});
    end
    idle(); idle(); idle();

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule